// File: doc/BRIEF.md
# Per-Timeslot Idle Code Inserter

This block sits in the transmit path of a 32-timeslot serial line at 2.048 Mbit/s. It replaces chosen timeslots of the outgoing bit stream with one shared, programmable 8-bit idle pattern. Data arrives one bit per enabled clock cycle. A frame sync pulse marks the first bit of each 256-bit frame. From that pulse the block counts where it is in the frame, so every bit is known to belong to a timeslot and to a position inside that timeslot.

Software programs the block through a small write port. Four byte-wide registers hold a 32-bit selection mask, and a fifth holds the idle pattern. For each timeslot the block decides once, on that timeslot's first bit, whether to pass the incoming bits or to send the idle pattern. It keeps that decision, and the pattern it latched, until the timeslot ends. The pattern is sent most significant bit first.

Top module: `ts_idle_inserter`

## Requirements
- R1: While reset is high and in the cycle after it, `dout` is 1. Reset clears the mask, the idle pattern and the frame position to 0, so the first enabled bit after reset is frame bit 0 and all data passes unchanged.
- R2: A cycle with `bit_en` and `fsync` both high carries frame bit 0. The position advances only on cycles with `bit_en` high. After bit 255 it wraps to 0 without a new sync pulse.
- R3: Write addresses 0 to 3 hold mask bytes 0 to 3. Bit j of mask byte k selects channel 8k+j+1, which occupies frame bits 8(8k+j) through 8(8k+j)+7.
- R4: A selected channel's 8 bits are replaced by the idle pattern. An unselected channel's bits are copied from `din`.
- R5: Write address 4 holds the idle pattern. Bit i (0 to 7) of a selected timeslot carries pattern bit 7-i, so the MSB goes first.
- R6: `dout` is registered and changes only at the clock edge that ends a `bit_en` cycle. In cycles with `bit_en` low it holds its value.
- R7: The select decision and the pattern are captured on each timeslot's first bit. A write in that same cycle, or any later write within the timeslot, takes effect from the next timeslot. A timeslot is never part data and part pattern.
- R8: A sync pulse in the middle of a frame restarts the position at bit 0 in that cycle.
- R9: Writes to addresses 5 to 7 change neither the mask nor the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One serial bit is present on `din` this cycle |
| fsync | input | 1 | With `bit_en`, marks frame bit 0 |
| din | input | 1 | Incoming serial data |
| dout | output | 1 | Outgoing serial data, registered |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 mask bytes, 4 idle pattern) |
| wr_data | input | 8 | Register write data |

## Verification
A register write and the first bit of a timeslot can land in the same clock cycle. The latch must then capture the value from before the write. The bench provokes this with targeted writes placed on positions that are multiples of 8. It also spreads random writes over every bit position of random frames. A reference model in the bench applies each write only after it has resolved the slot-start capture for that cycle. Every output bit is compared against the model, so a design that lets the new value leak into the current timeslot fails on the first differing bit.

// File: rtl/ts_idle_pkg.sv
package ts_idle_pkg;

  // Derived sizes shared by the submodules.
  function automatic int unsigned mask_regs(input int unsigned slots, input int unsigned code_w);
    return slots / code_w;
  endfunction

  function automatic int unsigned frame_bits(input int unsigned slots, input int unsigned code_w);
    return slots * code_w;
  endfunction

endpackage

// File: rtl/ts_reg_bank.sv
module ts_reg_bank
  import ts_idle_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output logic [SLOTS-1:0]  mask_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned NREGS = mask_regs(SLOTS, CODE_W);

  logic [SLOTS-1:0]  mask_q;
  logic [CODE_W-1:0] code_q;

  // One byte-wide mask register per address; the byte order is fixed by channel number.
  for (genvar k = 0; k < NREGS; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[k*CODE_W +: CODE_W] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
        mask_q[k*CODE_W +: CODE_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (wr_en && (wr_addr == ADDR_W'(NREGS))) begin
      code_q <= wr_data;
    end
  end

  assign mask_o = mask_q;
  assign code_o = code_q;

endmodule

// File: rtl/ts_frame_pos.sv
module ts_frame_pos
  import ts_idle_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_en,
  input  logic                        fsync,
  output logic [$clog2(SLOTS)-1:0]    slot_idx,
  output logic [$clog2(CODE_W)-1:0]   bit_idx,
  output logic                        slot_start
);

  localparam int unsigned FBITS = frame_bits(SLOTS, CODE_W);
  localparam int unsigned POS_W = $clog2(FBITS);
  localparam int unsigned IDX_W = $clog2(CODE_W);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] nxt_pos;

  // A sync pulse forces the current bit to be frame bit 0.
  assign cur_pos = fsync ? '0 : pos_q;
  assign nxt_pos = (cur_pos == POS_W'(FBITS - 1)) ? '0 : cur_pos + POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (bit_en) begin
      pos_q <= nxt_pos;
    end
  end

  assign slot_idx   = cur_pos[POS_W-1:IDX_W];
  assign bit_idx    = cur_pos[IDX_W-1:0];
  assign slot_start = (cur_pos[IDX_W-1:0] == '0);

endmodule

// File: rtl/ts_slot_mux.sv
module ts_slot_mux #(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned CODE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_en,
  input  logic                       din,
  input  logic                       slot_start,
  input  logic [$clog2(SLOTS)-1:0]   slot_idx,
  input  logic [$clog2(CODE_W)-1:0]  bit_idx,
  input  logic [SLOTS-1:0]           mask,
  input  logic [CODE_W-1:0]          code,
  output logic                       sel_q,
  output logic [CODE_W-1:0]          code_q,
  output logic                       dout
);

  localparam int unsigned IDX_W = $clog2(CODE_W);

  logic              sel_now;
  logic [CODE_W-1:0] code_now;
  logic [IDX_W-1:0]  msb_idx;
  logic              dout_q;

  // On a timeslot's first bit the live registers are used; afterwards the captured copies.
  assign sel_now  = slot_start ? mask[slot_idx] : sel_q;
  assign code_now = slot_start ? code : code_q;
  assign msb_idx  = IDX_W'(CODE_W - 1) - bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      code_q <= '0;
    end else if (bit_en && slot_start) begin
      sel_q  <= sel_now;
      code_q <= code_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= 1'b1;
    end else if (bit_en) begin
      dout_q <= sel_now ? code_now[msb_idx] : din;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/ts_idle_inserter.sv
module ts_idle_inserter
  import ts_idle_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic              din,
  output logic              dout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data
);

  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned IDX_W  = $clog2(CODE_W);

  logic [SLOTS-1:0]  mask_w;
  logic [CODE_W-1:0] code_w;
  logic [SLOT_W-1:0] slot_idx_w;
  logic [IDX_W-1:0]  bit_idx_w;
  logic              slot_start_w;
  logic              sel_q_w;
  logic [CODE_W-1:0] code_q_w;

  ts_reg_bank #(
    .SLOTS (SLOTS),
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .mask_o (mask_w),
    .code_o (code_w)
  );

  ts_frame_pos #(
    .SLOTS (SLOTS),
    .CODE_W(CODE_W)
  ) u_pos (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .slot_idx  (slot_idx_w),
    .bit_idx   (bit_idx_w),
    .slot_start(slot_start_w)
  );

  ts_slot_mux #(
    .SLOTS (SLOTS),
    .CODE_W(CODE_W)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .din       (din),
    .slot_start(slot_start_w),
    .slot_idx  (slot_idx_w),
    .bit_idx   (bit_idx_w),
    .mask      (mask_w),
    .code      (code_w),
    .sel_q     (sel_q_w),
    .code_q    (code_q_w),
    .dout      (dout)
  );

endmodule

// File: rtl/ts_idle_inserter_chk.sv
module ts_idle_inserter_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bit_en,
  input logic                      din,
  input logic                      dout,
  input logic                      slot_start,
  input logic [$clog2(CODE_W)-1:0] bit_idx,
  input logic                      sel_q,
  input logic [CODE_W-1:0]         code_q
);

  localparam int unsigned IDX_W = $clog2(CODE_W);

  logic [IDX_W-1:0] msb_idx;
  logic             code_bit;
  assign msb_idx  = IDX_W'(CODE_W - 1) - bit_idx;
  assign code_bit = code_q[msb_idx];

  // R1: line idles high through reset and the cycle after it
  p_reset_high_r1: assert property (@(posedge clk) $past(rst) |-> dout);

  // R6: no bit strobe, no output change
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(dout));

  // R4: inside an unselected timeslot the input bit is copied
  p_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !slot_start && !sel_q) |=> (dout == $past(din)));

  // R5: inside a selected timeslot the captured pattern goes out MSB first
  p_insert_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !slot_start && sel_q) |=> (dout == $past(code_bit)));

  // R7: captured decision and pattern change only on a timeslot's first bit
  p_slot_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && slot_start) |=> ($stable(sel_q) && $stable(code_q)));

endmodule

bind ts_idle_inserter ts_idle_inserter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .din       (din),
  .dout      (dout),
  .slot_start(slot_start_w),
  .bit_idx   (bit_idx_w),
  .sel_q     (sel_q_w),
  .code_q    (code_q_w)
);

// File: tb/ts_idle_inserter_tb.sv
module ts_idle_inserter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       fsync = 1'b0;
  logic       din = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       dout;

  always #2 clk = ~clk;

  ts_idle_inserter u_dut (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .fsync  (fsync),
    .din    (din),
    .dout   (dout),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state derived from the requirements.
  logic [31:0] m_mask = '0;
  logic [7:0]  m_idle = '0;
  int          m_pos  = 0;
  logic        m_sel  = 1'b0;
  logic [7:0]  m_code = '0;
  logic        m_exp  = 1'b1;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: drives one cycle, then checks dout at the next negedge.
  task automatic step(input logic be, input logic fs, input logic d,
                      input logic we, input logic [2:0] wa, input logic [7:0] wd,
                      input string req);
    int cur;
    bit_en = be; fsync = fs; din = d; wr_en = we; wr_addr = wa; wr_data = wd;
    if (be) begin
      cur = fs ? 0 : m_pos;
      if (cur % 8 == 0) begin
        m_sel  = m_mask[cur/8];
        m_code = m_idle;
      end
      m_exp = m_sel ? m_code[7 - (cur % 8)] : d;
      m_pos = (cur + 1) % 256;
    end
    if (we) begin
      if (wa < 3'd4)       m_mask[wa*8 +: 8] = wd;
      else if (wa == 3'd4) m_idle = wd;
    end
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0; wr_en = 1'b0;
    check(req, dout, m_exp);
  endtask

  task automatic write_reg(input logic [2:0] wa, input logic [7:0] wd, input string req);
    step(1'b0, 1'b0, 1'b0, 1'b1, wa, wd, req);
  endtask

  task automatic set_all(input logic [31:0] mk, input logic [7:0] cd, input string req);
    for (int k = 0; k < 4; k++) write_reg(3'(k), mk[k*8 +: 8], req);
    write_reg(3'd4, cd, req);
  endtask

  // Sends n bits; optional sync on the first, random writes and random gaps.
  task automatic send_bits(input int n, input bit sync_first, input int wr_rate,
                           input bit gaps, input string req);
    for (int b = 0; b < n; b++) begin
      logic we;
      logic [2:0] wa;
      we = (wr_rate != 0) && ($urandom % wr_rate == 0);
      wa = 3'($urandom % 5);
      step(1'b1, sync_first && (b == 0), 1'($urandom), we, wa, 8'($urandom),
           we ? "R7" : req);
      if (gaps && ($urandom % 4 == 0)) step(1'b0, 1'b0, 1'($urandom), 1'b0, 3'd0, 8'd0, "R6");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2143));
    repeat (3) @(negedge clk);
    check("R1", dout, 1'b1);            // R1: high during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", dout, 1'b1);            // R1: high in the cycle after reset

    // R1/R2: position starts at 0 after reset; mask clear so data passes
    send_bits(256, 1'b0, 0, 1'b0, "R1");

    // R5: every channel selected, pattern A5; gaps exercise R6
    set_all(32'hFFFF_FFFF, 8'hA5, "R6");
    send_bits(256, 1'b1, 0, 1'b1, "R5");

    // R3: mask byte order and bit order within each byte
    set_all(32'h8000_0201, 8'h3C, "R6");
    send_bits(256, 1'b1, 0, 1'b0, "R3");
    set_all(32'h0F00_5AF0, 8'hC3, "R6");
    send_bits(256, 1'b1, 0, 1'b0, "R3");

    // R9: unused addresses must not alias the mask or pattern
    write_reg(3'd5, 8'hFF, "R9");
    write_reg(3'd6, 8'hFF, "R9");
    write_reg(3'd7, 8'h00, "R9");
    send_bits(256, 1'b1, 0, 1'b0, "R9");

    // R8: sync in the middle of a frame restarts the count
    set_all(32'h1248_8421, 8'h96, "R6");
    send_bits(100, 1'b1, 0, 1'b0, "R8");
    send_bits(256, 1'b1, 0, 1'b0, "R8");

    // R7: writes landing exactly on a timeslot's first bit and mid-slot
    for (int s = 0; s < 8; s++) begin
      step(1'b1, s == 0, 1'($urandom), 1'b1, 3'd0, ~m_mask[7:0], "R7");
      send_bits(3, 1'b0, 0, 1'b0, "R7");
      step(1'b1, 1'b0, 1'($urandom), 1'b1, 3'd4, 8'($urandom), "R7");
      send_bits(3, 1'b0, 0, 1'b0, "R7");
    end

    // R2/R4/R7: random frames, some without sync (wrap), random writes and gaps
    for (int f = 0; f < 12; f++) begin
      set_all($urandom, 8'($urandom), "R6");
      send_bits(256, (f % 3) == 0, 11, f[0], (f % 3) == 0 ? "R4" : "R2");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule